// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is the master side of a four-wire synchronous serial link. A host writes one byte to start a transfer. The engine then asserts one active-low select line and generates the serial clock. It shifts eight bits out on the data-out line while it collects eight bits from the data-in line. When the byte is complete it raises a sticky completion flag that can serve as an interrupt. The received byte stays in a holding register until the next transfer completes.

Four configuration inputs set up each transfer, and all four are captured when the transfer starts:

- The polarity input sets the idle level of the serial clock. Data is driven on the edge that leaves the idle level and sampled on the edge that returns to it.
- The order input chooses whether the least or the most significant bit goes first. The choice applies to both directions.
- A two-bit rate code divides the system clock by 4, 16, 64 or 128.
- A select index chooses which slave's line is asserted.

A write that arrives while a transfer is running is dropped, and a collision bit records it.

Top module: `spiByteMaster`

## Requirements
- R1: Each transfer started by `wrEn` shifts all 8 bits of `wrData` out on `mosi` and collects 8 bits from `miso` into `rxData`, in full duplex.
- R2: With `cpol`=0, `sclk` idles low. `mosi` changes on the rising edge and `miso` is sampled on the falling edge.
- R3: With `cpol`=1, `sclk` idles high. `mosi` changes on the falling edge and `miso` is sampled on the rising edge.
- R4: With `lsbFirst`=1, bit 0 is sent and received first. With `lsbFirst`=0, bit 7 goes first. The order is the same for both directions.
- R5: `rateSel` codes 0, 1, 2 and 3 give a `sclk` period of 4, 16, 64 and 128 system clocks. The code is captured at the start of a transfer, and later changes have no effect on that transfer.
- R6: `doneFlag` goes to 1 when a transfer finishes. It stays at 1 until a `statusRd` pulse seen while it is set is followed by an `rxRd` pulse, or until a `flagClr` pulse. An `rxRd` pulse on its own does not clear it.
- R7: A `wrEn` pulse while `busy`=1 is ignored and sets `collision`. The running transfer is not changed. `collision` clears the same way as `doneFlag`.
- R8: While a transfer runs, only `csN[csSel]` is low. All of `csN` is high when the engine is idle.
- R9: `csN` goes low at least half a `sclk` period before the first `sclk` edge. It goes high at least half a period after the last edge. Between transfers `sclk` sits at the idle level set by `cpol`.
- R10: `rxData` keeps its value until the next transfer completes, including while a later transfer is in progress.
- R11: After reset, `csN` is all ones, `sclk` equals `cpol`, and `doneFlag`, `collision`, `busy` and `rxData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Clock idle level and edge pairing |
| lsbFirst | input | 1 | 1 selects least significant bit first |
| rateSel | input | 2 | Bit-rate code |
| csSel | input | $clog2(NUM_CS) | Index of the slave to select |
| wrEn | input | 1 | Write strobe for the transmit byte; starts a transfer when idle |
| wrData | input | DATA_W | Transmit byte |
| statusRd | input | 1 | Host read of the status (arms the flag clear) |
| rxRd | input | 1 | Host read of the receive byte (completes the clear) |
| flagClr | input | 1 | Direct clear of the completion and collision bits |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| csN | output | NUM_CS | Active-low slave selects |
| rxData | output | DATA_W | Last received byte |
| doneFlag | output | 1 | Sticky end-of-transfer flag |
| collision | output | 1 | Sticky write-while-busy flag |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest behaviour to reach from the ports is a transfer that is disturbed partway through. That is, a second write and a change of rate code arrive while bits are still moving. The test must show that neither one alters the byte on the wire, the byte received or the clock period. The bench reaches this by pulsing `wrEn` with different data and changing `rateSel` a few cycles after the start. A model slave attached to the serial lines keeps recording the bits sent and timing the clock edges throughout, so any effect of the disturbance shows up in its records. The same slave checks the edge pairing: it changes `miso` only on the leaving edge, so a master that sampled on the wrong edge would collect a shifted byte.

// File: rtl/spiMasterPkg.sv
package spiMasterPkg;

  // Strobes from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic load;    // capture configuration and transmit byte
    logic toggle;  // flip the serial clock
    logic drive;   // present the next outgoing bit
    logic sample;  // take in one incoming bit
    logic finish;  // release select, publish received byte
  } spiStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } spiStateT;

endpackage

// File: rtl/spiMasterCtrl.sv
module spiMasterCtrl
  import spiMasterPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int DIV3   = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] rateSel,
  output spiStrobeT  strb,
  output logic       busy
);

  localparam int MAX01  = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX23  = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAXDIV = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int HALF_W = (MAXDIV / 2 > 1) ? $clog2(MAXDIV / 2) : 1;
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  spiStateT              state;
  logic [1:0]            rateL;
  logic [HALF_W-1:0]     halfCnt;
  logic [EDGE_W-1:0]     edgeCnt;
  logic                  tick;

  // Last count value of a half bit period for a rate code
  function automatic logic [HALF_W-1:0] halfLast(input logic [1:0] sel);
    case (sel)
      2'd0:    halfLast = HALF_W'(DIV0 / 2 - 1);
      2'd1:    halfLast = HALF_W'(DIV1 / 2 - 1);
      2'd2:    halfLast = HALF_W'(DIV2 / 2 - 1);
      default: halfLast = HALF_W'(DIV3 / 2 - 1);
    endcase
  endfunction

  assign tick = (halfCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rateL   <= '0;
      halfCnt <= '0;
      edgeCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (wrEn) begin
            state   <= ST_SHIFT;
            rateL   <= rateSel;
            halfCnt <= halfLast(rateSel);
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            halfCnt <= halfLast(rateL);
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(EDGES - 1)) state <= ST_TRAIL;
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        ST_TRAIL: begin
          if (tick) state <= ST_IDLE;
          else      halfCnt <= halfCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && wrEn;
    strb.toggle = (state == ST_SHIFT) && tick;
    strb.drive  = strb.toggle && !edgeCnt[0];
    strb.sample = strb.toggle && edgeCnt[0];
    strb.finish = (state == ST_TRAIL) && tick;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spiMasterDatapath.sv
module spiMasterDatapath
  import spiMasterPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic              busy,
  input  logic              wrEn,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic [CS_W-1:0]   csSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusRd,
  input  logic              rxRd,
  input  logic              flagClr,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              collision
);

  logic [DATA_W-1:0] txSh, rxSh, rxReg;
  logic              mosiR, sclkR, lsbL, csOn, doneR, collR, armed;
  logic [CS_W-1:0]   csIdx;
  logic              hostClear;

  assign hostClear = flagClr || (rxRd && armed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      rxSh  <= '0;
      mosiR <= 1'b0;
      sclkR <= 1'b0;
      lsbL  <= 1'b0;
      csOn  <= 1'b0;
      csIdx <= '0;
    end else begin
      if (strb.load) begin
        txSh  <= wrData;
        sclkR <= cpol;
        lsbL  <= lsbFirst;
        csIdx <= csSel;
        csOn  <= 1'b1;
      end
      if (strb.toggle) sclkR <= !sclkR;
      if (strb.drive) begin
        if (lsbL) begin
          mosiR <= txSh[0];
          txSh  <= {1'b0, txSh[DATA_W-1:1]};
        end else begin
          mosiR <= txSh[DATA_W-1];
          txSh  <= {txSh[DATA_W-2:0], 1'b0};
        end
      end
      if (strb.sample) begin
        if (lsbL) rxSh <= {miso, rxSh[DATA_W-1:1]};
        else      rxSh <= {rxSh[DATA_W-2:0], miso};
      end
      if (strb.finish) csOn <= 1'b0;
    end
  end

  // Receive holding register and sticky host flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      doneR <= 1'b0;
      collR <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (hostClear) begin
        doneR <= 1'b0;
        collR <= 1'b0;
        armed <= 1'b0;
      end else if (statusRd && doneR) begin
        armed <= 1'b1;
      end
      if (wrEn && busy) collR <= 1'b1;
      if (strb.finish) begin
        rxReg <= rxSh;
        doneR <= 1'b1;
        armed <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    assign csN[g] = !(csOn && (csIdx == CS_W'(g)));
  end

  assign sclk      = csOn ? sclkR : cpol;
  assign mosi      = mosiR;
  assign rxData    = rxReg;
  assign doneFlag  = doneR;
  assign collision = collR;

endmodule

// File: rtl/spiByteMaster.sv
module spiByteMaster
  import spiMasterPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4,
  parameter int DIV0   = 4,
  parameter int DIV1   = 16,
  parameter int DIV2   = 64,
  parameter int DIV3   = 128,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              lsbFirst,
  input  logic [1:0]        rateSel,
  input  logic [CS_W-1:0]   csSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              statusRd,
  input  logic              rxRd,
  input  logic              flagClr,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              collision,
  output logic              busy
);

  spiStrobeT strb;

  spiMasterCtrl #(
    .DATA_W(DATA_W), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rateSel(rateSel),
    .strb(strb), .busy(busy)
  );

  spiMasterDatapath #(
    .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_W(CS_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .wrEn(wrEn),
    .cpol(cpol), .lsbFirst(lsbFirst), .csSel(csSel), .wrData(wrData),
    .statusRd(statusRd), .rxRd(rxRd), .flagClr(flagClr), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .rxData(rxData),
    .doneFlag(doneFlag), .collision(collision)
  );

endmodule

// File: rtl/spiByteMasterChk.sv
module spiByteMasterChk #(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpol,
  input logic              wrEn,
  input logic              busy,
  input logic              sclk,
  input logic [NUM_CS-1:0] csN,
  input logic [DATA_W-1:0] rxData,
  input logic              doneFlag,
  input logic              collision,
  input logic              rxRd,
  input logic              flagClr
);

  AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R8

  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cpol)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !flagClr && !rxRd |=> doneFlag); // R6

  AST_DIRECT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    flagClr && !busy |=> !doneFlag && !collision); // R6

  AST_COLLISION_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && busy |=> collision); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> doneFlag && !busy); // R10

endmodule

bind spiByteMaster spiByteMasterChk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) uChk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .wrEn(wrEn), .busy(busy),
  .sclk(sclk), .csN(csN), .rxData(rxData), .doneFlag(doneFlag),
  .collision(collision), .rxRd(rxRd), .flagClr(flagClr)
);

// File: tb/tb_spiByteMaster.sv
`timescale 1ns/1ps
module tb_spiByteMaster;

  localparam int NUM_CS = 4;
  localparam real TCK = 8.0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpol = 1'b0, lsbFirst = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [1:0] csSel = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       statusRd = 1'b0, rxRd = 1'b0, flagClr = 1'b0;
  logic       miso = 1'b0;
  logic       sclk, mosi, doneFlag, collision, busy;
  logic [NUM_CS-1:0] csN;
  logic [7:0] rxData;

  int errors = 0;
  int checks = 0;

  always #4 clk = !clk;

  spiByteMaster dut (
    .clk(clk), .rstN(rstN), .cpol(cpol), .lsbFirst(lsbFirst),
    .rateSel(rateSel), .csSel(csSel), .wrEn(wrEn), .wrData(wrData),
    .statusRd(statusRd), .rxRd(rxRd), .flagClr(flagClr), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .rxData(rxData),
    .doneFlag(doneFlag), .collision(collision), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int divOf(input logic [1:0] r);
    case (r)
      2'd0: return 4;
      2'd1: return 16;
      2'd2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // One full transfer with a model slave; optional mid-transfer disturbance
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl,
                      input logic pol, input logic lsb, input logic [1:0] rate,
                      input logic [1:0] cs, input bit disturb, input string polReq);
    logic [7:0] cap = 8'h00;
    logic [NUM_CS-1:0] csSeen = '1;
    realtime tFall = 0, tFirst = 0, tSecond = 0, tLast = 0, tRise = 0;
    int half = divOf(rate) / 2;
    @(negedge clk);
    cpol = pol; lsbFirst = lsb; rateSel = rate; csSel = cs; wrData = tx;
    repeat (2) @(negedge clk);
    check(sclk == pol, polReq, "idle clock level before transfer", sclk, pol);
    fork
      begin : slaveModel
        wait (csN != '1);
        tFall = $realtime;
        for (int i = 0; i < 8; i++) begin
          int idx = lsb ? i : 7 - i;
          if (pol) @(negedge sclk); else @(posedge sclk);
          if (i == 0) begin tFirst = $realtime; csSeen = csN; end
          if (i == 1) tSecond = $realtime;
          miso = sl[idx];
          if (pol) @(posedge sclk); else @(negedge sclk);
          cap[idx] = mosi;
          tLast = $realtime;
        end
        wait (csN == '1);
        tRise = $realtime;
      end
      begin : hostSide
        @(negedge clk); wrEn = 1'b1;
        @(negedge clk); wrEn = 1'b0;
        if (disturb) begin
          repeat (3) @(negedge clk);
          wrData = ~tx; rateSel = ~rate; wrEn = 1'b1;
          @(negedge clk); wrEn = 1'b0;
          check(collision == 1'b1, "R7", "collision after busy write", collision, 1);
        end
        wait (doneFlag);
      end
    join
    @(negedge clk);
    check(cap == tx, "R1", "bits seen on mosi", cap, tx);
    check(rxData == sl, lsb ? "R4" : "R1", "received byte", rxData, sl);
    check(csSeen == ~(4'b1 << cs), "R8", "select pattern in transfer", csSeen, ~(4'b1 << cs));
    check(csN == '1, "R8", "selects released after", csN, 4'hF);
    check(tFirst - tFall >= half * TCK, "R9", "select lead time ns",
          int'(tFirst - tFall), int'(half * TCK));
    check(tRise - tLast >= half * TCK, "R9", "select trail time ns",
          int'(tRise - tLast), int'(half * TCK));
    check(int'(tSecond - tFirst) == int'(divOf(rate) * TCK), "R5", "clock period ns",
          int'(tSecond - tFirst), int'(divOf(rate) * TCK));
    check(sclk == pol, polReq, "idle clock level after transfer", sclk, pol);
    check(doneFlag == 1'b1, "R6", "done flag set", doneFlag, 1);
    rateSel = rate;
  endtask

  task automatic clearAll();
    pulse(flagClr);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(csN == '1, "R11", "csN after reset", csN, 4'hF);
    check(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
    check(doneFlag == 1'b0 && collision == 1'b0, "R11", "flags after reset",
          {doneFlag, collision}, 0);
    check(busy == 1'b0, "R11", "busy after reset", busy, 0);
    check(rxData == 8'h00, "R11", "rxData after reset", rxData, 0);
    @(negedge clk); cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R9", "idle sclk follows polarity", sclk, 1);
    cpol = 1'b0;
  endtask

  task automatic testPolarity0();
    clearAll();
    xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, "R2");
    clearAll();
    xfer(8'h81, 8'hC6, 1'b0, 1'b1, 2'd1, 2'd2, 1'b0, "R2");
  endtask

  task automatic testPolarity1();
    clearAll();
    xfer(8'h1E, 8'hB2, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0, "R3");
    clearAll();
    xfer(8'h6D, 8'h07, 1'b1, 1'b0, 2'd2, 2'd3, 1'b0, "R3");
  endtask

  task automatic testRates();
    clearAll();
    xfer(8'hF0, 8'h0F, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, "R2");
    clearAll();
    xfer(8'h5A, 8'hE1, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, "R3");
  endtask

  task automatic testCollision();
    clearAll();
    xfer(8'h93, 8'h4B, 1'b0, 1'b0, 2'd1, 2'd2, 1'b1, "R2");
    check(collision == 1'b1, "R7", "collision held after transfer", collision, 1);
    clearAll();
    check(collision == 1'b0, "R7", "collision cleared by direct clear", collision, 0);
  endtask

  task automatic testClearSequence();
    clearAll();
    xfer(8'h22, 8'h99, 1'b0, 1'b1, 2'd0, 2'd3, 1'b0, "R2");
    pulse(rxRd);
    @(negedge clk);
    check(doneFlag == 1'b1, "R6", "receive read alone keeps flag", doneFlag, 1);
    pulse(statusRd);
    @(negedge clk);
    check(doneFlag == 1'b1, "R6", "status read alone keeps flag", doneFlag, 1);
    pulse(rxRd);
    @(negedge clk);
    check(doneFlag == 1'b0, "R6", "status then receive read clears flag", doneFlag, 0);
  endtask

  task automatic testRxHold();
    clearAll();
    xfer(8'hC3, 8'h5E, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, "R2");
    clearAll();
    @(negedge clk); wrData = 8'h11; miso = 1'b1;
    fork
      begin
        @(negedge clk); wrEn = 1'b1;
        @(negedge clk); wrEn = 1'b0;
        repeat (40) @(negedge clk);
        check(rxData == 8'h5E, "R10", "rxData held during next transfer", rxData, 8'h5E);
        wait (doneFlag);
      end
    join
    @(negedge clk);
    check(rxData == 8'hFF, "R10", "rxData replaced on completion", rxData, 8'hFF);
  endtask

  initial begin
    #(TCK * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPolarity0();
    testPolarity1();
    testRates();
    testCollision();
    testClearSequence();
    testRxHold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule